// File: doc/BRIEF.md
# Set/Clear Interrupt Controller

This block gathers up to 32 interrupt lines and presents them to a processor as two request outputs and one wake-from-idle output. Each line takes either an external peripheral input or a shared software test bit. Each line can be set to trigger on a rising edge, a falling edge, either edge, a high level or a low level. Edge events are held in sticky rising and falling latches until software clears them.

Software reaches every per-line control field through three word addresses: a read address, a write-one-to-set address and a write-one-to-clear address. Two handlers can therefore change different lines' bits without a read-modify-write and without a lock. A per-line mask gates each line onto its request output, and a per-line routing bit picks request 0 or request 1. A per-line wake bit lets an active line raise the wake output, whatever its mask.

The register bus is a plain synchronous port: a write strobe, a byte address and a data word. Read data appears one cycle after the address is presented.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: Each control field sits in its own 16-byte group. The fields are: trigger bit 0 at 0x00, trigger bit 1 at 0x10, trigger bit 2 at 0x20, source select at 0x30, routing at 0x40, wake enable at 0x50 and mask at 0x60. In each group, base+0 reads the field, base+4 sets the bits written as 1, and base+8 clears the bits written as 1. Bits written as 0 leave the field unchanged.
- R2: The software test bit is bit 0 of a read/write register at 0x80. Bits 31:1 of that register read as zero. A source-select bit of 1 feeds the line from its external input; 0 feeds it from the test bit.
- R3: The trigger code of a line is {bit2,bit1,bit0}. 001 is rising edge, 010 falling edge, 011 either edge, 100 level high and 101 level low. 000, 110 and 111 keep the line inactive.
- R4: In an edge mode, a detected edge sets the line's rising latch (read at 0x70, cleared at 0x78) or falling latch (read at 0x90, cleared at 0x98). The latch stays set until a one is written to its clear address. A latched edge makes the line active.
- R5: If an edge is detected in the same cycle as a clear write to the same latch bit, the latch stays set.
- R6: In a level mode, the line is active exactly while its source is at the selected level. No latch is involved.
- R7: A line contributes to a request output only while its mask bit is 1. With all mask bits 0, both request outputs are 0.
- R8: An unmasked active line with routing bit 0 drives cpu_req0; with routing bit 1 it drives cpu_req1. The pending sets for the two outputs read at 0xA0 and 0xA4.
- R9: wake_req is the registered OR of the active lines whose wake bit is 1, regardless of mask.
- R10: External inputs pass through two synchronizer flops. A rising external input on a rising-edge line raises its request output on the fourth clock edge after the input changes. Read data is registered one cycle after the address.
- R11: A synchronous active-high reset clears every register, the latches and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | External interrupt inputs, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| cpu_req0 | output | 1 | Request output 0 |
| cpu_req1 | output | 1 | Request output 1 |
| wake_req | output | 1 | Wake-from-idle request |

## Verification
A corrupted control bit or edge latch shows up at the ports within one clock. It appears either in the registered read data for that field's read address or in cpu_req0, cpu_req1 or wake_req on the following edge. A wrong synchronizer depth or a missing output register moves the request edge off its fourth-cycle slot, which the per-cycle model comparison catches at once. A lost same-cycle edge during a latch clear reads back as a zero in the latch register one cycle later.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NFIELD       = 7;
  localparam int unsigned FLD_CFG0     = 0;
  localparam int unsigned FLD_CFG1     = 1;
  localparam int unsigned FLD_CFG2     = 2;
  localparam int unsigned FLD_SRC      = 3;
  localparam int unsigned FLD_ROUTE    = 4;
  localparam int unsigned FLD_WAKE     = 5;
  localparam int unsigned FLD_MASK     = 6;
  localparam int unsigned FIELD_STRIDE = 16;
  localparam int unsigned SET_OFS      = 4;
  localparam int unsigned CLR_OFS      = 8;
  localparam int unsigned OFS_RISE     = 'h70;
  localparam int unsigned OFS_TEST     = 'h80;
  localparam int unsigned OFS_FALL     = 'h90;
  localparam int unsigned OFS_PEND0    = 'hA0;
  localparam int unsigned OFS_PEND1    = 'hA4;

  localparam logic [2:0] TRIG_RISE = 3'b001;
  localparam logic [2:0] TRIG_FALL = 3'b010;
  localparam logic [2:0] TRIG_BOTH = 3'b011;
  localparam logic [2:0] TRIG_HIGH = 3'b100;
  localparam logic [2:0] TRIG_LOW  = 3'b101;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irqc_setclr_reg.sv
module irqc_setclr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q | set_v) & ~clr_v;
  end
endmodule

// File: rtl/irqc_line.sv
module irqc_line
  import irqc_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ext_sync,
  input  logic         test_bit,
  input  logic [N-1:0] src_sel,
  input  logic [N-1:0] cfg0,
  input  logic [N-1:0] cfg1,
  input  logic [N-1:0] cfg2,
  input  logic [N-1:0] rise_clr,
  input  logic [N-1:0] fall_clr,
  output logic [N-1:0] active,
  output logic [N-1:0] rise_q,
  output logic [N-1:0] fall_q
);
  logic [N-1:0] val, prev_q;
  logic [N-1:0] rise_en, fall_en, hi_en, lo_en;
  logic [N-1:0] rise_evt, fall_evt;

  for (genvar i = 0; i < N; i++) begin : g_mode
    logic [2:0] mode;
    assign mode       = {cfg2[i], cfg1[i], cfg0[i]};
    assign val[i]     = src_sel[i] ? ext_sync[i] : test_bit;
    assign rise_en[i] = (mode == TRIG_RISE) || (mode == TRIG_BOTH);
    assign fall_en[i] = (mode == TRIG_FALL) || (mode == TRIG_BOTH);
    assign hi_en[i]   = (mode == TRIG_HIGH);
    assign lo_en[i]   = (mode == TRIG_LOW);
  end

  assign rise_evt = val & ~prev_q & rise_en;
  assign fall_evt = ~val & prev_q & fall_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      prev_q <= val;
      // a fresh edge overrides a clear in the same cycle
      rise_q <= (rise_q & ~rise_clr) | rise_evt;
      fall_q <= (fall_q & ~fall_clr) | fall_evt;
    end
  end

  assign active = (rise_q & rise_en) | (fall_q & fall_en)
                | (val & hi_en) | (~val & lo_en);

  AST_RISE_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rise_q & $past(rise_q & ~rise_clr)) == $past(rise_q & ~rise_clr))); // R4
  AST_FALL_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((fall_q & $past(fall_q & ~fall_clr)) == $past(fall_q & ~fall_clr))); // R4
  AST_LATCH_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rise_q & ~$past(rise_q) & ~$past(rise_evt)) == '0)); // R4
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((rise_evt & rise_clr) != '0) |=> ((rise_q & $past(rise_evt & rise_clr)) == $past(rise_evt & rise_clr))); // R5
endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 cpu_req0,
  output logic                 cpu_req1,
  output logic                 wake_req
);
  localparam int unsigned N = NUM_LINES;

  logic [N-1:0] fld_q   [NFIELD];
  logic [N-1:0] fld_set [NFIELD];
  logic [N-1:0] fld_clr [NFIELD];
  logic [N-1:0] wbits, ext_sync, active, rise_q, fall_q;
  logic [N-1:0] rise_clr, fall_clr, pend0, pend1;
  logic         test_q;
  logic [DATA_W-1:0] rd_d;

  assign wbits = bus_wdata[N-1:0];

  for (genvar f = 0; f < NFIELD; f++) begin : g_fld
    assign fld_set[f] = (bus_we && bus_addr == ADDR_W'(f * FIELD_STRIDE + SET_OFS)) ? wbits : '0;
    assign fld_clr[f] = (bus_we && bus_addr == ADDR_W'(f * FIELD_STRIDE + CLR_OFS)) ? wbits : '0;
    irqc_setclr_reg #(.W(N)) u_reg (
      .clk(clk), .rst(rst), .set_v(fld_set[f]), .clr_v(fld_clr[f]), .q(fld_q[f])
    );
  end

  assign rise_clr = (bus_we && bus_addr == ADDR_W'(OFS_RISE + CLR_OFS)) ? wbits : '0;
  assign fall_clr = (bus_we && bus_addr == ADDR_W'(OFS_FALL + CLR_OFS)) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst)                                        test_q <= 1'b0;
    else if (bus_we && bus_addr == ADDR_W'(OFS_TEST)) test_q <= bus_wdata[0];
  end

  irqc_sync #(.W(N)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(ext_sync)
  );

  irqc_line #(.N(N)) u_line (
    .clk(clk), .rst(rst), .ext_sync(ext_sync), .test_bit(test_q),
    .src_sel(fld_q[FLD_SRC]), .cfg0(fld_q[FLD_CFG0]), .cfg1(fld_q[FLD_CFG1]),
    .cfg2(fld_q[FLD_CFG2]), .rise_clr(rise_clr), .fall_clr(fall_clr),
    .active(active), .rise_q(rise_q), .fall_q(fall_q)
  );

  assign pend0 = active & fld_q[FLD_MASK] & ~fld_q[FLD_ROUTE];
  assign pend1 = active & fld_q[FLD_MASK] &  fld_q[FLD_ROUTE];

  always_comb begin
    rd_d = '0;
    for (int f = 0; f < NFIELD; f++) begin
      if (bus_addr == ADDR_W'(f * FIELD_STRIDE)) rd_d[N-1:0] = fld_q[f];
    end
    if (bus_addr == ADDR_W'(OFS_RISE))  rd_d[N-1:0] = rise_q;
    if (bus_addr == ADDR_W'(OFS_FALL))  rd_d[N-1:0] = fall_q;
    if (bus_addr == ADDR_W'(OFS_PEND0)) rd_d[N-1:0] = pend0;
    if (bus_addr == ADDR_W'(OFS_PEND1)) rd_d[N-1:0] = pend1;
    if (bus_addr == ADDR_W'(OFS_TEST))  rd_d = {{(DATA_W-1){1'b0}}, test_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      cpu_req0  <= 1'b0;
      cpu_req1  <= 1'b0;
      wake_req  <= 1'b0;
    end else begin
      bus_rdata <= rd_d;
      cpu_req0  <= |pend0;
      cpu_req1  <= |pend1;
      wake_req  <= |(active & fld_q[FLD_WAKE]);
    end
  end

  AST_MASK_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
    (fld_q[FLD_MASK] == '0) |=> (!cpu_req0 && !cpu_req1)); // R7
  AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (fld_q[FLD_WAKE] == '0) |=> !wake_req); // R9
  AST_TESTBIT_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(OFS_TEST)) |=> (bus_rdata[DATA_W-1:1] == '0)); // R2
endmodule

// File: tb/tb_irq_setclr_ctrl.sv
`timescale 1ns/1ps
module tb_irq_setclr_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_req0, cpu_req1, wake_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_setclr_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_req0(cpu_req0),
    .cpu_req1(cpu_req1), .wake_req(wake_req)
  );

  // Behavioural reference: fields 0..6 = trig0, trig1, trig2, source, route, wake, mask
  logic [31:0] m_fld [7];
  logic [31:0] m_rise, m_fall, m_s1, m_s2, m_prev, m_rdata;
  logic        m_tb, m_req0, m_req1, m_wake;
  logic [31:0] v, a, p0, p1, nrd;

  function automatic bit in_mode(int code, int want);
    return code == want;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < 7; f++) m_fld[f] = '0;
      m_rise = '0; m_fall = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
      m_rdata = '0; m_tb = 0; m_req0 = 0; m_req1 = 0; m_wake = 0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        int code;
        code = {m_fld[2][i], m_fld[1][i], m_fld[0][i]};
        v[i] = m_fld[3][i] ? m_s2[i] : m_tb;
        a[i] = ((code == 1 || code == 3) && m_rise[i]) || ((code == 2 || code == 3) && m_fall[i])
            || (in_mode(code, 4) && v[i]) || (in_mode(code, 5) && !v[i]);
      end
      p0 = a & m_fld[6] & ~m_fld[4];
      p1 = a & m_fld[6] & m_fld[4];
      nrd = '0;
      for (int f = 0; f < 7; f++) if (bus_addr == 8'(f * 16)) nrd = m_fld[f];
      if (bus_addr == 8'h70) nrd = m_rise;
      if (bus_addr == 8'h90) nrd = m_fall;
      if (bus_addr == 8'hA0) nrd = p0;
      if (bus_addr == 8'hA4) nrd = p1;
      if (bus_addr == 8'h80) nrd = {31'b0, m_tb};
      m_rdata = nrd;
      m_req0 = (p0 != 0);
      m_req1 = (p1 != 0);
      m_wake = ((a & m_fld[5]) != 0);
      for (int i = 0; i < 32; i++) begin
        int code;
        bit clr_r, clr_f;
        code  = {m_fld[2][i], m_fld[1][i], m_fld[0][i]};
        clr_r = bus_we && bus_addr == 8'h78 && bus_wdata[i];
        clr_f = bus_we && bus_addr == 8'h98 && bus_wdata[i];
        if (clr_r) m_rise[i] = 0;
        if (clr_f) m_fall[i] = 0;
        if ((code == 1 || code == 3) && v[i] && !m_prev[i]) m_rise[i] = 1;
        if ((code == 2 || code == 3) && !v[i] && m_prev[i]) m_fall[i] = 1;
      end
      if (bus_we) begin
        for (int f = 0; f < 7; f++) begin
          if (bus_addr == 8'(f * 16 + 4)) m_fld[f] = m_fld[f] | bus_wdata;
          if (bus_addr == 8'(f * 16 + 8)) m_fld[f] = m_fld[f] & ~bus_wdata;
        end
        if (bus_addr == 8'h80) m_tb = bus_wdata[0];
      end
      m_prev = v;
      m_s2 = m_s1;
      m_s1 = irq_in;
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(bus_rdata, m_rdata, "R1 readback");
    chk({31'b0, cpu_req0}, {31'b0, m_req0}, "R8 req0");
    chk({31'b0, cpu_req1}, {31'b0, m_req1}, "R8 req1");
    chk({31'b0, wake_req}, {31'b0, m_wake}, "R9 wake");
  endtask

  task automatic cycle(input logic we, input logic [7:0] ad, input logic [31:0] d);
    bus_we = we; bus_addr = ad; bus_wdata = d;
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    chk(bus_rdata, 32'h0, "R11 rdata");
    chk({29'b0, cpu_req0, cpu_req1, wake_req}, 32'h0, "R11 outputs");
    rst = 1'b0;
    cycle(0, 8'h00, 0);

    // R1: set/clear with zero bits leaving the rest untouched
    cycle(1, 8'h24, 32'hFF00FF00);
    cycle(1, 8'h28, 32'h0F000F00);
    cycle(0, 8'h20, 0);
    chk(bus_rdata, 32'hF000F000, "R1 set/clear");
    cycle(1, 8'h28, 32'hFFFFFFFF);
    cycle(0, 8'h20, 0);
    chk(bus_rdata, 32'h0, "R1 clear all");

    // R2: test bit register, reserved bits read zero
    cycle(1, 8'h80, 32'hFFFFFFFF);
    cycle(0, 8'h80, 0);
    chk(bus_rdata, 32'h1, "R2 test bit");
    cycle(1, 8'h80, 32'h0);

    // R10: external rising edge on line 8 reaches cpu_req0 on the fourth edge
    cycle(1, 8'h04, 32'h100);
    cycle(1, 8'h34, 32'h100);
    cycle(1, 8'h64, 32'h100);
    cycle(0, 8'h00, 0);
    irq_in[8] = 1'b1;
    cycle(0, 8'h00, 0);
    cycle(0, 8'h00, 0);
    cycle(0, 8'h00, 0);
    chk({31'b0, cpu_req0}, 32'h0, "R10 not before fourth edge");
    cycle(0, 8'h00, 0);
    chk({31'b0, cpu_req0}, 32'h1, "R10 fourth edge");
    cycle(1, 8'h78, 32'h100);
    cycle(1, 8'h68, 32'h100);
    cycle(0, 8'h00, 0);

    // R5: edge from the test bit coincides with a clear of line 0's rising latch
    cycle(1, 8'h04, 32'h1);
    cycle(1, 8'h64, 32'h1);
    cycle(1, 8'h54, 32'h1);
    cycle(1, 8'h80, 32'h1);
    cycle(1, 8'h78, 32'h1);
    cycle(0, 8'h70, 0);
    chk(bus_rdata & 32'h1, 32'h1, "R5 edge beats clear");
    chk({31'b0, cpu_req0}, 32'h1, "R8 routed to req0");
    chk({31'b0, wake_req}, 32'h1, "R9 wake enabled");
    cycle(1, 8'h78, 32'h1);
    cycle(0, 8'h70, 0);
    chk(bus_rdata & 32'h1, 32'h0, "R4 clear releases latch");

    // R3 R4 R6 R7 R8 R9: random traffic against the reference model
    for (int k = 0; k < 1500; k++) begin
      int pick;
      logic [7:0] ad;
      logic [31:0] d;
      if (($urandom % 4) == 0) irq_in = irq_in ^ (32'h1 << ($urandom % 32));
      pick = $urandom % 20;
      d = (($urandom % 2) == 0) ? $urandom : (32'h1 << ($urandom % 32));
      if (pick < 14)       ad = 8'(((pick / 2) * 16) + ((pick % 2) ? 8 : 4));
      else if (pick == 14) ad = 8'h78;
      else if (pick == 15) ad = 8'h98;
      else if (pick == 16) ad = 8'h80;
      else                 ad = 8'h00;
      if (pick >= 17) begin
        int r;
        r = $urandom % 11;
        ad = (r < 7) ? 8'(r * 16) : (r == 7) ? 8'h70 : (r == 8) ? 8'h90 : (r == 9) ? 8'hA0 : 8'hA4;
        cycle(0, ad, 0);
      end else begin
        cycle(1, ad, d);
      end
    end

    // R7: all masks cleared drops both requests
    cycle(1, 8'h68, 32'hFFFFFFFF);
    cycle(0, 8'h00, 0);
    cycle(0, 8'h00, 0);
    chk({30'b0, cpu_req0, cpu_req1}, 32'h0, "R7 masked");
    finish_run();
  end
endmodule